// File: doc/BRIEF.md
# Prescaled Watchdog Reset Timer

This block guards a system against runaway software. A timeout counter advances on ticks from a prescaler that divides the oscillator clock by a power of two chosen in software. If software fails to restart the count before the counter rolls past its maximum value, the block raises a reset request pulse for the rest of the system. The same pulse also returns the block itself to its idle state.

Software reaches the block through one 8-bit control register on a plain write-strobe / read-data bus. The register holds an enable bit, a write-one restart command and a 3-bit divider code. An external synchronous hardware reset also returns the register to its idle state. With the default 16-bit counter, the timeout is 65536 × divider oscillator cycles. At 40 MHz that is roughly 13 ms with the smallest divider and roughly 1.68 s with the largest.

Top module: `wdog_timer`

## Requirements
- R1: While `rst` is high and after it is released, `rd_data` reads 8'h00 and `wdt_rst_o` is low.
- R2: The register layout is: bit 7 holds the enable, bits 2..0 hold the divider code, and bits 6..3 always read 0. Bit 5 is the restart command and is never stored. A write updates the enable and the code at the next clock edge.
- R3: Once the enable is written to 1, `wdt_rst_o` first reads high exactly 2^(code+3) × 2^CNT_W clock edges after the enabling write edge.
- R4: The timeout doubles with each step of the divider code (code 0 divides by 8, code 7 divides by 1024).
- R5: A write with bit 5 set zeroes both the prescaler and the counter. A full timeout is then measured from that write edge.
- R6: While the enable is 0, no reset request is ever raised. Writing the enable to 0 discards the progress made so far, so a later enable starts a full timeout.
- R7: Each reset request is high for exactly RST_CYCLES consecutive cycles.
- R8: A reset request returns the enable and the divider code to 0. The block then stays quiet until software enables it again.
- R9: The hardware reset input clears the enable mid-count, and no reset request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read data |
| wdt_rst_o | output | 1 | Registered reset request pulse |

## Verification
The bench measures the exact edge on which the request rises for the divider codes 0, 1, 2 and 7. An off-by-one in the prescaler mask or in the overflow compare would move that edge by a full prescaler period or by one cycle. A restart issued partway through a count must push the timeout out to a full period after the restart; a design that clears only one of the two counters would fire early. Disabling, a hardware reset mid-count and the clearing of the enable by the block's own request are all checked by watching that no further pulse appears. The width of the request pulse is also counted, since a wrong load value would lengthen or shorten it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W   = 8;
  localparam int EN_POS  = 7;
  localparam int CLR_POS = 5;
  localparam int SEL_W   = 3;
  localparam int MIN_SHIFT = 3;
  localparam int PRE_W   = MIN_SHIFT + (1 << SEL_W) - 1;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             sys_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output wdog_ctrl_t       ctrl,
  output logic             restart,
  output logic [REG_W-1:0] rd_data
);
  wdog_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.en  <= wr_data[EN_POS];
      ctrl_q.sel <= wr_data[SEL_W-1:0];
    end
  end

  // restart is a command strobe only; it is never held in the register
  assign restart = wr_en & wr_data[CLR_POS] & ~sys_rst;
  assign ctrl    = ctrl_q;

  always_comb begin
    rd_data                = '0;
    rd_data[EN_POS]        = ctrl_q.en;
    rd_data[SEL_W-1:0]     = ctrl_q.sel;
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             hold,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  int unsigned      shamt;

  always_comb begin
    shamt = int'(sel) + MIN_SHIFT;
    mask  = ~({PRE_W{1'b1}} << shamt);
  end

  always_ff @(posedge clk) begin
    if (hold || !run) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // all low bits set marks the end of one divided period
  assign tick = run && !hold && ((pre_q & mask) == mask);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic hold,
  input  logic run,
  input  logic tick,
  output logic ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (hold || !run) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  assign ovf = run && !hold && tick && (cnt_q == CNT_MAX);
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  output logic req
);
  localparam int LW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [LW-1:0] LOAD = LW'(RST_CYCLES - 1);
  logic [LW-1:0] left_q;
  logic          req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      req_q  <= 1'b0;
    end else if (ovf) begin
      left_q <= LOAD;
      req_q  <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      req_q  <= 1'b1;
    end else begin
      req_q  <= 1'b0;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             wdt_rst_o
);
  wdog_ctrl_t ctrl;
  logic       restart;
  logic       sys_rst;
  logic       tick;
  logic       ovf;
  logic       hold;

  assign sys_rst = rst | wdt_rst_o;
  assign hold    = sys_rst | restart;

  wdog_ctrl_reg u_reg (
    .clk     (clk),
    .sys_rst (sys_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .restart (restart),
    .rd_data (rd_data)
  );

  wdog_prescaler u_pre (
    .clk  (clk),
    .hold (hold),
    .run  (ctrl.en),
    .sel  (ctrl.sel),
    .tick (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .hold (hold),
    .run  (ctrl.en),
    .tick (tick),
    .ovf  (ovf)
  );

  wdog_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rgen (
    .clk (clk),
    .rst (rst),
    .ovf (ovf),
    .req (wdt_rst_o)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       wdt_rst_o
);
  logic        prev_q;
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      run_q  <= 0;
    end else begin
      prev_q <= wdt_rst_o;
      if (wdt_rst_o && !prev_q) run_q <= 1;
      else if (wdt_rst_o)       run_q <= run_q + 1;
    end
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[6:3] == 4'b0000); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wdt_rst_o) |=> rd_data == ($past(wr_data) & 8'h87)); // R2
  AST_FIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> $past(rd_data[7])); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (prev_q && !wdt_rst_o) |-> run_q == RST_CYCLES); // R7
  AST_REQ_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |=> rd_data[7] == 1'b0); // R8
endmodule

bind wdog_timer wdog_timer_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .wdt_rst_o (wdt_rst_o)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CNT_W  = 6;
  localparam int PULSE  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_rst_o;
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CNT_W(CNT_W), .RST_CYCLES(PULSE)) u_wdog_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wdt_rst_o(wdt_rst_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog expired: act=%0d exp<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n, output int fired);
    fired = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst_o) fired = 1;
    end
  endtask

  // counts edges after the last write edge until the request is seen
  task automatic measure(output int n);
    n = 1;
    if (wdt_rst_o) return;
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (wdt_rst_o) return;
    end
  endtask

  task automatic pulse_len(output int w);
    w = 0;
    while (wdt_rst_o && w < 50) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rd_data in reset", rd_data, 0);
    check("R1 req in reset", wdt_rst_o, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 0);
  endtask

  task automatic t_layout();
    wr(8'h7F);
    check("R2 unused and command bits read 0", rd_data, 8'h07);
    wr(8'h00);
    check("R2 cleared", rd_data, 8'h00);
  endtask

  task automatic t_timeout(input int code, input string tag);
    int n, w;
    wr(8'h80 | 8'(code));
    check({tag, " readback"}, rd_data, 8'h80 | code);
    measure(n);
    check(tag, n, (8 << code) << CNT_W);
    pulse_len(w);
    check("R7 pulse width", w, PULSE);
    check("R8 enable and code cleared", rd_data, 0);
  endtask

  task automatic t_restart();
    int n, f, w;
    wr(8'h80);
    idle(400, f);
    check("R5 no early fire", f, 0);
    wr(8'hA0);
    check("R5 command reads 0", rd_data, 8'h80);
    measure(n);
    check("R5 full timeout after restart", n, 8 << CNT_W);
    pulse_len(w);
  endtask

  task automatic t_disable();
    int n, f, w;
    wr(8'h80);
    idle(400, f);
    wr(8'h00);
    idle(1500, f);
    check("R6 quiet while disabled", f, 0);
    wr(8'h80);
    measure(n);
    check("R6 full timeout after re-enable", n, 8 << CNT_W);
    pulse_len(w);
    idle(1500, f);
    check("R8 quiet after own reset", f, 0);
  endtask

  task automatic t_hwreset();
    int f;
    wr(8'h81);
    idle(300, f);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 enable cleared by hw reset", rd_data, 0);
    idle(2000, f);
    check("R9 no request after hw reset", f, 0);
  endtask

  initial begin
    t_reset();
    t_layout();
    t_timeout(0, "R3 code0 timeout");
    t_timeout(1, "R4 code1 timeout");
    t_timeout(2, "R4 code2 timeout");
    t_timeout(7, "R4 code7 timeout");
    t_restart();
    t_disable();
    t_hwreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule